// File: doc/BRIEF.md
# Serial Converter Output Shifter

This block models the digital output side of a 14-bit converter with a serial read port. A falling edge on the active-low start input begins a conversion. The busy output then stays high for a fixed, parameterised number of system clock cycles. When busy drops, the value on the parallel result input is captured into an output register. An external reader then pulls the captured result out over a serial data line, one bit per serial clock period.

The serial clock comes from outside and is sampled in the system clock domain. Each serial word is sixteen bits long: two zero bits, then the result from bit 13 down to bit 0. Between reads the data line is released. Instead of a real tri-state net, the block drives a separate output-enable signal, and the data pin reads 0 whenever the enable is low. If the reader sends more than sixteen clock pulses, the shifter starts the word again and keeps the line driven. This lasts until the next conversion completes.

Top module: `ser_adc_shifter`

## Requirements
- R1: After reset, busy, sdata_oe and sdata are all 0.
- R2: A high-to-low transition of conv_start_n while busy is low raises busy on the next clock edge, and busy stays high for exactly CONV_CYC clock cycles.
- R3: A high-to-low transition of conv_start_n while busy is high is ignored: the busy period neither restarts nor gets longer.
- R4: On the edge where busy falls, the output register takes the value of sample_in, the bit position returns to the start of the word and sdata_oe goes low.
- R5: The serial word is {2'b00, result[13:0]}, sent from word bit 15 down to word bit 0. The first rising sclk edge after R4 sets sdata_oe and presents word bit 15 (a zero).
- R6: Each falling sclk edge while enabled moves to the next lower word bit. After the 15th falling edge, sdata carries result bit 0. Data changes only after a falling sclk edge, never after a rising one.
- R7: On the 16th falling sclk edge of a normal read, sdata_oe goes low, and sdata reads 0 from then on. It stays that way until another rising sclk edge or a conversion.
- R8: A rising sclk edge after a completed 16-bit word restarts the word at bit 15 with sdata_oe high. From then on, every 16th falling edge wraps back to bit 15. sdata_oe stays high, even with sclk stopped, until the next conversion ends.
- R9: Reads during a conversion return the previously captured result.
- R10: Every output is registered, and each sclk or conv_start_n edge reaches the outputs on the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; sclk and conv_start_n are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_n | input | 1 | Active-low start; a falling edge begins a conversion |
| sclk | input | 1 | Serial read clock from the external reader |
| sample_in | input | RES_W | Parallel result, captured when busy falls |
| busy | output | 1 | High while a conversion is in progress |
| sdata | output | 1 | Serial data bit; 0 while the line is released |
| sdata_oe | output | 1 | High while the data line is driven |

## Verification
The hardest state to reach is the sticky over-clocked mode. It needs a completed 16-bit read and then further serial pulses, and it must then hold across a stopped serial clock and several word wraps. The bench gets there by sending 20 pulses, idling with sclk low, and then sending 28 more, comparing every half period with an arithmetic model of the word position. A start edge placed inside a busy period, and a partial read taken during a conversion while sample_in already shows the next value, cover the two cases where new input must not leak through early.

// File: rtl/ser_adc_pkg.sv
package ser_adc_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/ser_edge_det.sv
module ser_edge_det #(
  parameter logic INIT = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                din,
  output ser_adc_pkg::edge_t  ev
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= INIT;
    else     din_q <= din;
  end

  always_comb begin
    ev.rise = !din_q && din;
    ev.fall = din_q && !din;
  end
endmodule

// File: rtl/ser_conv_timer.sv
module ser_conv_timer #(
  parameter int CONV_CYC = 40,
  parameter int RES_W    = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int CW = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      result <= '0;
    end else if (done) begin
      busy   <= 1'b0;
      result <= sample_in;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CONV_CYC - 1);
    end
  end
endmodule

// File: rtl/ser_out_shifter.sv
module ser_out_shifter #(
  parameter int RES_W  = 14,
  parameter int LEAD_Z = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [RES_W-1:0]    result,
  input  ser_adc_pkg::edge_t  ev,
  output logic                sdata,
  output logic                sdata_oe
);
  localparam int WORD_W = RES_W + LEAD_Z;
  localparam int PW     = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] word;
  logic [PW-1:0]     pos;
  logic              wrapped;
  logic              next_bit;

  assign word = {{LEAD_Z{1'b0}}, result};

  always_comb begin
    next_bit = 1'b0;
    for (int i = 0; i < WORD_W - 1; i++) begin
      if (int'(pos) == i) next_bit = word[WORD_W-2-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      pos      <= '0;
      wrapped  <= 1'b0;
      sdata_oe <= 1'b0;
      sdata    <= 1'b0;
    end else if (ev.rise) begin
      if (!sdata_oe && pos == '0) begin
        sdata_oe <= 1'b1;
        sdata    <= word[WORD_W-1];
      end else if (int'(pos) == WORD_W) begin
        pos      <= '0;
        wrapped  <= 1'b1;
        sdata_oe <= 1'b1;
        sdata    <= word[WORD_W-1];
      end
    end else if (ev.fall && sdata_oe) begin
      if (int'(pos) == WORD_W - 1) begin
        if (wrapped) begin
          pos   <= '0;
          sdata <= word[WORD_W-1];
        end else begin
          pos      <= PW'(WORD_W);
          sdata_oe <= 1'b0;
          sdata    <= 1'b0;
        end
      end else begin
        pos   <= pos + 1'b1;
        sdata <= next_bit;
      end
    end
  end
endmodule

// File: rtl/ser_adc_shifter.sv
module ser_adc_shifter #(
  parameter int CONV_CYC = 40,
  parameter int RES_W    = 14,
  parameter int LEAD_Z   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic             sdata,
  output logic             sdata_oe
);
  ser_adc_pkg::edge_t start_ev;
  ser_adc_pkg::edge_t sclk_ev;
  logic               conv_done;
  logic [RES_W-1:0]   result;

  ser_edge_det #(.INIT(1'b1)) u_start_edge (
    .clk (clk), .rst (rst), .din (conv_start_n), .ev (start_ev)
  );

  ser_edge_det #(.INIT(1'b0)) u_sclk_edge (
    .clk (clk), .rst (rst), .din (sclk), .ev (sclk_ev)
  );

  ser_conv_timer #(.CONV_CYC(CONV_CYC), .RES_W(RES_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start     (start_ev.fall),
    .sample_in (sample_in),
    .busy      (busy),
    .done      (conv_done),
    .result    (result)
  );

  ser_out_shifter #(.RES_W(RES_W), .LEAD_Z(LEAD_Z)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (conv_done),
    .result   (result),
    .ev       (sclk_ev),
    .sdata    (sdata),
    .sdata_oe (sdata_oe)
  );
endmodule

// File: rtl/ser_adc_shifter_chk.sv
module ser_adc_shifter_chk #(
  parameter int CONV_CYC = 40
) (
  input logic clk,
  input logic rst,
  input logic conv_start_n,
  input logic sclk,
  input logic busy,
  input logic sdata,
  input logic sdata_oe
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_len == CONV_CYC); // R2

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!$past(conv_start_n) && $past(conv_start_n, 2))); // R2

  AST_OE_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe) |-> ($past(sclk) && !$past(sclk, 2))); // R5

  AST_OE_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(sdata_oe) |-> ((!$past(sclk) && $past(sclk, 2)) || $fell(busy))); // R7

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe |-> !sdata); // R7

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> ((!$past(sclk) && $past(sclk, 2)) || $rose(sdata_oe) || $fell(busy))); // R6
endmodule

bind ser_adc_shifter ser_adc_shifter_chk #(.CONV_CYC(CONV_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .conv_start_n (conv_start_n),
  .sclk         (sclk),
  .busy         (busy),
  .sdata        (sdata),
  .sdata_oe     (sdata_oe)
);

// File: tb/ser_adc_shifter_bench.sv
`timescale 1ns/1ps
module ser_adc_shifter_bench;
  localparam int C  = 40;
  localparam int RW = 14;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          conv_start_n = 1'b1;
  logic          sclk = 1'b0;
  logic [RW-1:0] sample_in = '0;
  logic          busy, sdata, sdata_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [WW-1:0] m_word = '0;
  int            m_pos  = 0;
  bit            m_oe   = 0;
  bit            m_wrap = 0;
  bit            m_sd   = 0;

  always #2.5 clk = ~clk;

  ser_adc_shifter #(.CONV_CYC(C), .RES_W(RW), .LEAD_Z(2)) u_ser_adc_shifter (
    .clk (clk), .rst (rst), .conv_start_n (conv_start_n), .sclk (sclk),
    .sample_in (sample_in), .busy (busy), .sdata (sdata), .sdata_oe (sdata_oe)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_model(string req);
    chk(req, int'(sdata_oe), int'(m_oe));
    chk(req, int'(sdata), int'(m_sd));
  endtask

  task automatic pulse(string req);
    sclk = 1'b1;
    if (!m_oe && m_pos == 0) begin
      m_oe = 1; m_sd = m_word[WW-1];
    end else if (m_pos == WW) begin
      m_pos = 0; m_wrap = 1; m_oe = 1; m_sd = m_word[WW-1];
    end
    @(negedge clk);
    check_model(req);
    sclk = 1'b0;
    if (m_oe) begin
      if (m_pos == WW-1) begin
        if (m_wrap) begin m_pos = 0; m_sd = m_word[WW-1]; end
        else begin m_pos = WW; m_oe = 0; m_sd = 0; end
      end else begin
        m_pos++; m_sd = m_word[WW-1-m_pos];
      end
    end
    @(negedge clk);
    check_model(req);
  endtask

  task automatic convert(logic [RW-1:0] v, bit extra_start);
    int cnt = 0;
    sample_in    = v;
    conv_start_n = 1'b0;
    @(negedge clk);
    while (busy && cnt < 1000) begin
      cnt++;
      if (extra_start && cnt == 3) conv_start_n = 1'b1;
      if (extra_start && cnt == 5) conv_start_n = 1'b0;
      @(negedge clk);
    end
    chk(extra_start ? "R3 busy length" : "R2 busy length", cnt, C);
    m_word = {2'b00, v}; m_pos = 0; m_oe = 0; m_wrap = 0; m_sd = 0;
    check_model("R4 rearm");
    conv_start_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 oe", int'(sdata_oe), 0);
    chk("R1 sdata", int'(sdata), 0);

    for (int i = 0; i < 14; i++) begin
      logic [RW-1:0] v;
      if (i == 0)      v = '0;
      else if (i == 1) v = '1;
      else if (i < 10) v = RW'(1 << (i + 3));
      else             v = RW'((i * 4679 + 341) & 16'h3fff);
      convert(v, i == 3);
      pulse("R5 first bit");
      for (int p = 1; p < WW - 1; p++) pulse("R6 shift");
      pulse("R7 release");
      repeat (3) @(negedge clk);
      chk("R7 idle oe", int'(sdata_oe), 0);
      chk("R7 idle sdata", int'(sdata), 0);
    end

    convert(14'h2b5c, 1'b0);
    for (int p = 0; p < 20; p++) pulse("R8 overclock");
    repeat (6) @(negedge clk);
    chk("R8 held oe", int'(sdata_oe), 1);
    check_model("R8 held data");
    for (int p = 0; p < 28; p++) pulse("R8 wrap");

    convert(14'h1234, 1'b0);
    chk("R4 clears overclock", int'(sdata_oe), 0);
    sample_in    = 14'h3c0f;
    conv_start_n = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 5; p++) pulse("R9 old result");
    while (busy) @(negedge clk);
    conv_start_n = 1'b1;
    m_word = {2'b00, 14'h3c0f}; m_pos = 0; m_oe = 0; m_wrap = 0; m_sd = 0;
    check_model("R4 reload");
    for (int p = 0; p < WW; p++) pulse("R10 new word");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule